// File: doc/BRIEF.md
# GMII Single-Packet Port

This peripheral joins an 8-bit processor I/O bus to a gigabit media-independent interface. The processor sees a window of eight byte-wide locations at a parameterised base address, aligned to eight bytes. Through this window it pulls a received frame out one byte at a time, and it fills an outgoing frame the same way before starting its transmission.

Each direction has one packet buffer. A frame that arrives while an unread packet is held is thrown away in full. Neither GMII side has back-pressure: receive bytes are taken on every clock with receive-valid high, and transmit bytes leave on every clock with transmit-enable high. The processor side uses single-cycle read and write strobes with no wait states. Read data is combinational and is valid in the cycle of the strobe. Status flags change only as a side effect of the data and control accesses and of line events.

Top module: `gmii_pkt_port`

## Requirements
- R1: Only addresses whose upper five bits match the base address are decoded. Accesses outside the window, and accesses to offsets 6 and 7, have no effect. Reads of those locations, and reads of write-only offsets 1 and 5, return 0x00.
- R2: Status (offset 0) bit 0 goes to 1 on the clock edge after receive-valid falls at the end of a clean, accepted frame. It goes to 0 on the edge at which the final byte of that packet is read.
- R3: Offsets 2 and 3 return the low byte and the high byte of the held packet's length, which is the number of receive-valid clocks. Both read 0x00 when no packet is held.
- R4: Each read of offset 4 returns the next byte of the held packet in arrival order. When no packet is held, it returns 0x00 and moves no pointer.
- R5: A frame whose first valid clock finds a packet held is discarded in full. A frame whose first valid clock coincides with the read of the final held byte is accepted.
- R6: A frame with receive-error high on any of its valid clocks is discarded and leaves status bit 0 at 0.
- R7: Writing 1 to bit 0 of offset 1 transmits the buffered bytes in write order. Transmit-enable rises on the second rising edge after the write and stays high for exactly one clock per byte.
- R8: Status bit 1 goes to 1 on the edge where transmit-enable falls. The next write to offset 5 clears it.
- R9: While a transmission runs, writes to offsets 5 and 1 are ignored. A start command with an empty transmit buffer sends nothing.
- R10: After a transmission, the transmit buffer is empty, so the next packet starts at its own first byte.
- R11: After reset, status reads 0x00, and transmit-enable and transmit-data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the bus side and the line side |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | Processor I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| gmii_rxd | input | 8 | Receive byte |
| gmii_rx_dv | input | 1 | Receive-valid |
| gmii_rx_er | input | 1 | Receive-error |
| gmii_txd | output | 8 | Transmit byte |
| gmii_tx_en | output | 1 | Transmit-enable |

## Verification
Two events can land in the same cycle: the processor reads the last byte of a held packet, and the first valid clock of a new frame arrives. The bench lines up that read strobe and the first receive-valid clock on one edge, then drains the second frame. The coincidence is judged correct only if that frame was accepted intact, with the correct length and bytes. It also checks the mirror case, where a frame starts while a packet is still held: that frame must vanish, and status bit 0 must read 0 after the held packet is drained.

// File: rtl/gmii_pkt_pkg.sv
package gmii_pkt_pkg;
  localparam logic [2:0] OFF_STAT   = 3'd0;
  localparam logic [2:0] OFF_CTRL   = 3'd1;
  localparam logic [2:0] OFF_LEN_LO = 3'd2;
  localparam logic [2:0] OFF_LEN_HI = 3'd3;
  localparam logic [2:0] OFF_RXDATA = 3'd4;
  localparam logic [2:0] OFF_TXDATA = 3'd5;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_TAKE = 2'd1,
    RX_SKIP = 2'd2
  } rx_mode_t;
endpackage

// File: rtl/gmii_pkt_ram.sv
module gmii_pkt_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/gmii_rx_path.sv
module gmii_rx_path
  import gmii_pkt_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int LEN_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_d,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic             rd_pop,
  output logic             avail,
  output logic [LEN_W-1:0] pkt_len,
  output logic [7:0]       rd_byte
);
  rx_mode_t         mode;
  logic [AW-1:0]    wptr;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] rcnt;
  logic             bad;
  logic             last_pop;
  logic             free;
  logic             we;
  logic [7:0]       mem_q;

  assign last_pop = rd_pop && avail && (rcnt == pkt_len - LEN_W'(1));
  assign free     = !avail || last_pop;
  assign we       = rx_dv && ((mode == RX_TAKE) || (mode == RX_IDLE && free));

  gmii_pkt_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (wptr),
    .wdata (rx_d),
    .raddr (rcnt[AW-1:0]),
    .rdata (mem_q)
  );

  assign rd_byte = avail ? mem_q : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= RX_IDLE;
      wptr    <= '0;
      cnt     <= '0;
      bad     <= 1'b0;
      avail   <= 1'b0;
      pkt_len <= '0;
      rcnt    <= '0;
    end else begin
      if (rd_pop && avail) begin
        if (last_pop) begin
          avail   <= 1'b0;
          pkt_len <= '0;
          rcnt    <= '0;
        end else begin
          rcnt <= rcnt + LEN_W'(1);
        end
      end
      if (we) wptr <= wptr + AW'(1);
      unique case (mode)
        RX_IDLE: begin
          if (rx_dv) begin
            if (free) begin
              mode <= RX_TAKE;
              cnt  <= LEN_W'(1);
              bad  <= rx_er;
            end else begin
              mode <= RX_SKIP;
            end
          end
        end
        RX_TAKE: begin
          if (rx_dv) begin
            cnt <= cnt + LEN_W'(1);
            bad <= bad | rx_er;
          end else begin
            if (!bad && cnt != '0) begin
              avail   <= 1'b1;
              pkt_len <= cnt;
            end
            mode <= RX_IDLE;
            cnt  <= '0;
            bad  <= 1'b0;
            wptr <= '0;
          end
        end
        default: begin
          if (!rx_dv) mode <= RX_IDLE;
        end
      endcase
    end
  end

  // R2
  avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail) |-> (!$past(rx_dv) && $past(mode) == RX_TAKE));
  // R6
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail) |-> !$past(bad));
  // R2
  avail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(avail) |-> $past(rd_pop));
  // R3
  len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avail |-> pkt_len == '0);
  // R5
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RX_SKIP) |=> $stable(avail) || $fell(avail));
endmodule

// File: rtl/gmii_tx_path.sv
module gmii_tx_path #(
  parameter int DEPTH = 2048,
  parameter int LEN_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_push,
  input  logic [7:0] wr_byte,
  input  logic       go,
  output logic [7:0] tx_d,
  output logic       tx_en,
  output logic       done
);
  logic             busy;
  logic             fin_q;
  logic [AW-1:0]    twptr;
  logic [LEN_W-1:0] tcnt;
  logic [LEN_W-1:0] trd;
  logic [7:0]       mem_q;
  logic             push_ok;

  assign push_ok = wr_push && !busy;

  gmii_pkt_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (push_ok),
    .waddr (twptr),
    .wdata (wr_byte),
    .raddr (trd[AW-1:0]),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fin_q <= 1'b0;
      twptr <= '0;
      tcnt  <= '0;
      trd   <= '0;
      tx_d  <= 8'h00;
      tx_en <= 1'b0;
      done  <= 1'b0;
    end else if (busy) begin
      tx_en <= 1'b1;
      tx_d  <= mem_q;
      trd   <= trd + LEN_W'(1);
      if (trd == tcnt - LEN_W'(1)) begin
        busy  <= 1'b0;
        fin_q <= 1'b1;
        twptr <= '0;
        tcnt  <= '0;
      end
    end else begin
      tx_en <= 1'b0;
      tx_d  <= 8'h00;
      fin_q <= 1'b0;
      if (fin_q) done <= 1'b1;
      if (push_ok) begin
        twptr <= twptr + AW'(1);
        tcnt  <= tcnt + LEN_W'(1);
        done  <= 1'b0;
      end else if (go && tcnt != '0) begin
        busy <= 1'b1;
        trd  <= '0;
      end
    end
  end

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> !done);
  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(tx_en));
  // R9
  busy_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_push) |=> (tcnt == $past(tcnt)) || (tcnt == '0));
  // R7
  start_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(busy));
endmodule

// File: rtl/gmii_pkt_port.sv
module gmii_pkt_port
  import gmii_pkt_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h40,
  parameter int DEPTH = 2048,
  parameter int LEN_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic       io_rd,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic [7:0] gmii_rxd,
  input  logic       gmii_rx_dv,
  input  logic       gmii_rx_er,
  output logic [7:0] gmii_txd,
  output logic       gmii_tx_en
);
  logic             hit;
  logic [2:0]       off;
  logic             rx_avail;
  logic [LEN_W-1:0] rx_len;
  logic [7:0]       rx_byte;
  logic             tx_done;

  assign hit = (io_addr[7:3] == BASE_ADDR[7:3]);
  assign off = io_addr[2:0];

  gmii_rx_path #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_d    (gmii_rxd),
    .rx_dv   (gmii_rx_dv),
    .rx_er   (gmii_rx_er),
    .rd_pop  (io_rd && hit && off == OFF_RXDATA),
    .avail   (rx_avail),
    .pkt_len (rx_len),
    .rd_byte (rx_byte)
  );

  gmii_tx_path #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_push (io_wr && hit && off == OFF_TXDATA),
    .wr_byte (io_wdata),
    .go      (io_wr && hit && off == OFF_CTRL && io_wdata[0]),
    .tx_d    (gmii_txd),
    .tx_en   (gmii_tx_en),
    .done    (tx_done)
  );

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && hit) begin
      unique case (off)
        OFF_STAT:   io_rdata = {6'b0, tx_done, rx_avail};
        OFF_LEN_LO: io_rdata = rx_len[7:0];
        OFF_LEN_HI: io_rdata = 8'(rx_len >> 8);
        OFF_RXDATA: io_rdata = rx_byte;
        default:    io_rdata = 8'h00;
      endcase
    end
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && hit) |-> io_rdata == 8'h00);
endmodule

// File: tb/test_gmii_pkt_port.sv
`timescale 1ns/1ps
module test_gmii_pkt_port;
  localparam logic [7:0] A_STAT = 8'h40;
  localparam logic [7:0] A_CTRL = 8'h41;
  localparam logic [7:0] A_LLO  = 8'h42;
  localparam logic [7:0] A_LHI  = 8'h43;
  localparam logic [7:0] A_RXD  = 8'h44;
  localparam logic [7:0] A_TXD  = 8'h45;

  logic clk = 0, rst_n = 0;
  logic [7:0] io_addr = 0, io_wdata = 0, gmii_rxd = 0;
  logic io_rd = 0, io_wr = 0, gmii_rx_dv = 0, gmii_rx_er = 0;
  logic [7:0] io_rdata, gmii_txd;
  logic gmii_tx_en;
  int checks = 0, bad = 0;
  logic [7:0] fr [0:255];
  logic [7:0] tq [0:255];
  logic [7:0] mon [0:255];
  int mon_n = 0, rises = 0;
  logic prev_en = 0;

  always #4 clk = ~clk;

  gmii_pkt_port i_gmii_pkt_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .gmii_rxd(gmii_rxd),
    .gmii_rx_dv(gmii_rx_dv), .gmii_rx_er(gmii_rx_er), .gmii_txd(gmii_txd),
    .gmii_tx_en(gmii_tx_en)
  );

  always @(negedge clk) begin
    if (gmii_tx_en) begin
      if (mon_n < 256) mon[mon_n] = gmii_txd;
      mon_n++;
      if (!prev_en) rises++;
    end
    prev_en = gmii_tx_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 0; io_addr = 0;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0; io_addr = 0;
  endtask

  task automatic fill_frame(input int n);
    for (int i = 0; i < n; i++) fr[i] = 8'($urandom);
  endtask

  task automatic send_frame(input int n, input int errpos);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      gmii_rx_dv = 1; gmii_rxd = fr[i]; gmii_rx_er = (i == errpos);
    end
    @(negedge clk);
    gmii_rx_dv = 0; gmii_rx_er = 0; gmii_rxd = 0;
  endtask

  function automatic logic [7:0] exp_status(input bit avail, input bit done);
    return {6'b0, done, avail};
  endfunction

  task automatic drain(input int n, input string req);
    logic [7:0] d;
    io_read(A_LLO, d); chk(d == 8'(n), "R3 len low", d, 8'(n));
    io_read(A_LHI, d); chk(d == 8'(n >> 8), "R3 len high", d, 8'(n >> 8));
    for (int i = 0; i < n; i++) begin
      io_read(A_RXD, d);
      chk(d == fr[i], req, d, fr[i]);
    end
    io_read(A_STAT, d); chk(d[0] == 1'b0, "R2 avail cleared", d[0], 0);
    io_read(A_LLO, d); chk(d == 8'h00, "R3 len zero when empty", d, 0);
  endtask

  task automatic tx_run(input int n, input bit poke);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      tq[i] = 8'($urandom);
      io_write(A_TXD, tq[i]);
    end
    mon_n = 0; rises = 0;
    io_write(A_CTRL, 8'h01);
    chk(gmii_tx_en == 1'b0, "R7 not yet enabled", gmii_tx_en, 0);
    @(negedge clk);
    chk(gmii_tx_en == 1'b1, "R7 enable after two edges", gmii_tx_en, 1);
    if (poke) begin
      io_write(A_TXD, 8'hEE);
      io_write(A_CTRL, 8'h01);
    end
    while (gmii_tx_en) @(negedge clk);
    io_read(A_STAT, d);
    chk(d[1] == 1'b1, "R8 done set", d[1], 1);
    chk(mon_n == n, "R7 byte count", mon_n, n);
    chk(rises == 1, "R7 single burst", rises, 1);
    for (int i = 0; i < n && i < 256; i++)
      chk(mon[i] == tq[i], "R10 tx byte order", mon[i], tq[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] lastb;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    io_read(A_STAT, d); chk(d == exp_status(0, 0), "R11 status", d, 0);
    chk(gmii_tx_en == 0 && gmii_txd == 0, "R11 tx idle", gmii_tx_en, 0);
    // R4 empty read returns zero
    io_read(A_RXD, d); chk(d == 8'h00, "R4 empty data read", d, 0);

    // Random receive frames, some with errors
    for (int k = 0; k < 12; k++) begin
      n = 1 + int'($urandom % 60);
      fill_frame(n);
      if (k % 4 == 3) begin
        send_frame(n, int'($urandom % n));
        io_read(A_STAT, d); chk(d[0] == 0, "R6 error frame dropped", d[0], 0);
      end else begin
        send_frame(n, -1);
        io_read(A_STAT, d); chk(d[0] == 1, "R2 avail set", d[0], 1);
        drain(n, "R4 rx byte order");
      end
    end

    // Long frame exercising high length byte
    fill_frame(256);
    send_frame(300, -1);
    io_read(A_LHI, d); chk(d == 8'h01, "R3 high byte 300", d, 1);
    io_read(A_LLO, d); chk(d == 8'h2C, "R3 low byte 300", d, 8'h2C);
    for (int i = 0; i < 300; i++) io_read(A_RXD, d);
    io_read(A_STAT, d); chk(d[0] == 0, "R2 drained long", d[0], 0);

    // R5 drop while held
    fill_frame(6); send_frame(6, -1);
    for (int i = 0; i < 6; i++) tq[i] = fr[i];
    fill_frame(9); send_frame(9, -1);
    for (int i = 0; i < 6; i++) fr[i] = tq[i];
    drain(6, "R5 held packet intact");

    // R1 window and reserved offsets
    fill_frame(4); send_frame(4, -1);
    io_read(8'h4C, d); chk(d == 8'h00, "R1 outside window read", d, 0);
    io_read(8'h46, d); chk(d == 8'h00, "R1 reserved offset 6", d, 0);
    io_read(8'h47, d); chk(d == 8'h00, "R1 reserved offset 7", d, 0);
    io_read(A_TXD, d); chk(d == 8'h00, "R1 write-only reads zero", d, 0);
    drain(4, "R1 no pop outside window");

    // R5 coincidence: last read and new frame start on one edge
    fill_frame(5); send_frame(5, -1);
    for (int i = 0; i < 4; i++) io_read(A_RXD, d);
    lastb = fr[4];
    fill_frame(7);
    @(negedge clk);
    io_addr = A_RXD; io_rd = 1; gmii_rx_dv = 1; gmii_rxd = fr[0];
    #1 d = io_rdata;
    chk(d == lastb, "R5 final byte at coincidence", d, lastb);
    @(negedge clk);
    io_rd = 0; io_addr = 0;
    for (int i = 1; i < 7; i++) begin
      gmii_rxd = fr[i];
      @(negedge clk);
    end
    gmii_rx_dv = 0; gmii_rxd = 0;
    io_read(A_STAT, d); chk(d[0] == 1, "R5 coincident frame accepted", d[0], 1);
    drain(7, "R5 coincident frame bytes");

    // Transmit: random lengths
    for (int k = 0; k < 5; k++) tx_run(1 + int'($urandom % 40), 0);
    io_write(A_TXD, 8'h5A);
    io_read(A_STAT, d); chk(d[1] == 0, "R8 done cleared by write", d[1], 0);
    // Transmit the pending byte as a 1-byte packet in a fresh run
    mon_n = 0;
    io_write(A_CTRL, 8'h01);
    repeat (4) @(negedge clk);
    chk(mon_n == 1 && mon[0] == 8'h5A, "R10 single byte packet", mon[0], 8'h5A);

    // R9 writes ignored during transmit, then R10 fresh packet
    tx_run(12, 1);
    tx_run(2, 0);
    mon_n = 0;
    io_write(A_CTRL, 8'h01);
    repeat (6) @(negedge clk);
    chk(mon_n == 0, "R9 empty start sends nothing", mon_n, 0);
    io_write(8'h49, 8'h01);
    repeat (4) @(negedge clk);
    chk(mon_n == 0, "R1 control outside window", mon_n, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule